// File: doc/BRIEF.md
# Multichannel DMA Address Sequencer

This block schedules word transfers for eight independent DMA channels and produces the source and destination address of every transfer. Each side of a channel (source and destination) has a resource code, a base address, a signed increment and a mode: linear, or circular with a buffer length. A channel also has a transfer count, a service interval and an interrupt selector. Software loads a descriptor while the channel is idle, then sets the channel's enable bit.

On every clock the sequencer finds the channels that may issue. A channel may issue when it is enabled, has transfers left, has finished its service interval, and has both of its resources ready. A round-robin arbiter picks one of these channels. The chosen channel's request leaves on a registered port, and its addresses then step forward. When the last transfer of a channel issues, the channel turns itself off and pulses one interrupt line.

Top module: `dma_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, req_valid is 0, irq is all zero and every active bit is 0.
- R2: In linear mode the k-th request of a side (k from 0) carries base + k*inc, taken modulo 2^AW, where inc is a two's complement value.
- R3: In circular mode the address is base + offset. The offset starts at 0 and advances by inc. It wraps back into [0, len) by adding or subtracting len, for both positive and negative inc (|inc| <= len).
- R4: After a request from a channel with interval I, that channel issues its next request at least I+1 cycles later. With I = 0 it may issue every cycle.
- R5: At most one request issues per cycle. The winner is the first eligible channel found when searching upward (with wrap) from the channel after the last one granted. After reset the search starts at channel 0.
- R6: A channel is skipped in any cycle in which res_ready is low for its source resource or its destination resource. Resource codes: 0 data memory X, 1 data memory Y, 2 program memory, 3 peripheral bus.
- R7: The request that uses up a channel's count clears that channel's active bit at the same clock edge. In the same cycle as that request, irq[sel] pulses for exactly one cycle.
- R8: A descriptor write (cfg_we) to a channel whose active bit is 1 has no effect. A write to an idle channel loads the descriptor, resets both offsets to 0 and makes the channel eligible at once, with no interval wait.
- R9: A request appears on the outputs at the first rising clock edge after the cycle in which its channel was eligible. An enable or disable write (ctl_we) takes effect at that same edge, and it overrides the self-clear.
- R10: An interrupt selector of NIRQ or more produces no interrupt pulse when the channel completes.
- R11: An enabled channel loaded with a count of 0 never issues a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | CHW | Channel addressed by the descriptor write |
| cfg_src_base | input | AW | Source base address |
| cfg_src_inc | input | AW | Source increment, two's complement |
| cfg_src_len | input | AW | Source circular buffer length |
| cfg_src_circ | input | 1 | Source circular mode |
| cfg_src_res | input | 2 | Source resource code |
| cfg_dst_base | input | AW | Destination base address |
| cfg_dst_inc | input | AW | Destination increment, two's complement |
| cfg_dst_len | input | AW | Destination circular buffer length |
| cfg_dst_circ | input | 1 | Destination circular mode |
| cfg_dst_res | input | 2 | Destination resource code |
| cfg_count | input | CW | Number of transfers |
| cfg_interval | input | IW | Service interval in cycles |
| cfg_irq_sel | input | SELW | Interrupt line chosen for completion |
| ctl_we | input | 1 | Enable bit write strobe |
| ctl_ch | input | CHW | Channel addressed by the enable write |
| ctl_en | input | 1 | New enable bit value |
| res_ready | input | NRES | Per-resource readiness |
| req_valid | output | 1 | A transfer request issues this cycle |
| req_ch | output | CHW | Granted channel |
| req_src_res | output | 2 | Source resource of the request |
| req_src_addr | output | AW | Source address |
| req_dst_res | output | 2 | Destination resource of the request |
| req_dst_addr | output | AW | Destination address |
| irq | output | NIRQ | Completion interrupt pulses |
| active | output | NCH | Per-channel enable bits |

## Verification
Everything the block produces is due exactly one rising edge after the inputs that cause it: a request, its addresses, the completion interrupt and the change to the active bits. The bench drives all inputs on the falling edge and predicts that next edge in a model that works from the requirements. It then compares every output on the following falling edge, so each prediction is checked exactly once. Directed sequences cover linear and circular stepping, interval spacing, resource stalls, ignored descriptor writes, and unused or zero settings. A long random run mixes all of these.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    RES_XMEM = 2'd0,
    RES_YMEM = 2'd1,
    RES_PMEM = 2'd2,
    RES_PBUS = 2'd3
  } res_e;
  localparam int RES_W = $bits(res_e);
  localparam int RES_N = 1 << RES_W;
endpackage

// File: rtl/dma_seq_side.sv
// One address side of a channel: holds base, step and mode, keeps the offset.
module dma_seq_side #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] inc_i,
  input  logic [AW-1:0] len_i,
  input  logic          circ_i,
  output logic [AW-1:0] addr_o
);
  localparam int EW = AW + 2;

  logic [AW-1:0] base_q, inc_q, len_q, off_q;
  logic          circ_q;
  logic signed [EW-1:0] sum, lenx, wrapped;
  logic [AW-1:0] nxt;
  logic unused_hi;

  always_comb begin
    sum  = $signed({2'b00, off_q}) + $signed({{2{inc_q[AW-1]}}, inc_q});
    lenx = $signed({2'b00, len_q});
    if (!circ_q)          wrapped = sum;
    else if (sum < 0)     wrapped = sum + lenx;
    else if (sum >= lenx) wrapped = sum - lenx;
    else                  wrapped = sum;
    nxt = wrapped[AW-1:0];
  end
  assign unused_hi = ^wrapped[EW-1:AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0; inc_q <= '0; len_q <= '0; circ_q <= 1'b0; off_q <= '0;
    end else if (load) begin
      base_q <= base_i; inc_q <= inc_i; len_q <= len_i; circ_q <= circ_i;
      off_q  <= '0;
    end else if (step) begin
      off_q <= nxt;
    end
  end

  assign addr_o = base_q + off_q;
endmodule

// File: rtl/dma_seq_chan.sv
// Per-channel state: count, interval throttle, enable and two address sides.
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 12,
  parameter int IW   = 6,
  parameter int SELW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hit,
  input  logic [AW-1:0]    src_base, src_inc, src_len,
  input  logic             src_circ,
  input  logic [RES_W-1:0] src_res,
  input  logic [AW-1:0]    dst_base, dst_inc, dst_len,
  input  logic             dst_circ,
  input  logic [RES_W-1:0] dst_res,
  input  logic [CW-1:0]    count,
  input  logic [IW-1:0]    interval,
  input  logic [SELW-1:0]  irq_sel,
  input  logic             ctl_hit,
  input  logic             ctl_en,
  input  logic             grant,
  input  logic [RES_N-1:0] res_ready,
  output logic             eligible,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr,
  output logic [RES_W-1:0] src_res_o,
  output logic [RES_W-1:0] dst_res_o,
  output logic             done,
  output logic [SELW-1:0]  sel_o,
  output logic             active_o
);
  logic             act_q;
  logic [CW-1:0]    rem_q;
  logic [IW-1:0]    wait_q, ival_q;
  logic [SELW-1:0]  sel_q;
  logic [RES_W-1:0] sres_q, dres_q;
  logic             load;

  assign load = cfg_hit && !act_q;
  assign done = grant && (rem_q == CW'(1));
  assign eligible = act_q && (rem_q != '0) && (wait_q == '0)
                    && res_ready[sres_q] && res_ready[dres_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0; wait_q <= '0; ival_q <= '0; sel_q <= '0;
      sres_q <= '0; dres_q <= '0;
    end else if (load) begin
      rem_q <= count; wait_q <= '0; ival_q <= interval; sel_q <= irq_sel;
      sres_q <= src_res; dres_q <= dst_res;
    end else if (grant) begin
      rem_q  <= rem_q - CW'(1);
      wait_q <= ival_q;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          act_q <= 1'b0;
    else if (ctl_hit) act_q <= ctl_en;
    else if (done)    act_q <= 1'b0;
  end

  dma_seq_side #(.AW(AW)) i_src (
    .clk(clk), .rst(rst), .load(load), .step(grant),
    .base_i(src_base), .inc_i(src_inc), .len_i(src_len), .circ_i(src_circ),
    .addr_o(src_addr)
  );
  dma_seq_side #(.AW(AW)) i_dst (
    .clk(clk), .rst(rst), .load(load), .step(grant),
    .base_i(dst_base), .inc_i(dst_inc), .len_i(dst_len), .circ_i(dst_circ),
    .addr_o(dst_addr)
  );

  assign src_res_o = sres_q;
  assign dst_res_o = dres_q;
  assign sel_o     = sel_q;
  assign active_o  = act_q;
endmodule

// File: rtl/dma_seq_rr.sv
// Round-robin picker: searches upward from the entry after the last winner.
module dma_seq_rr #(
  parameter int N = 8,
  localparam int IXW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  output logic [N-1:0]   gnt,
  output logic [IXW-1:0] idx,
  output logic           any
);
  logic [IXW-1:0] ptr_q;

  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (int'(ptr_q) + i) % N;
      if (!any && req[k]) begin
        any    = 1'b1;
        idx    = IXW'(k);
        gnt[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= IXW'(N - 1);
    else if (any) ptr_q <= idx;
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int AW   = 16,
  parameter int CW   = 12,
  parameter int IW   = 6,
  parameter int NIRQ = 6,
  localparam int CHW  = $clog2(NCH),
  localparam int SELW = $clog2(NIRQ),
  localparam int NRES = RES_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [AW-1:0]    cfg_src_base,
  input  logic [AW-1:0]    cfg_src_inc,
  input  logic [AW-1:0]    cfg_src_len,
  input  logic             cfg_src_circ,
  input  logic [RES_W-1:0] cfg_src_res,
  input  logic [AW-1:0]    cfg_dst_base,
  input  logic [AW-1:0]    cfg_dst_inc,
  input  logic [AW-1:0]    cfg_dst_len,
  input  logic             cfg_dst_circ,
  input  logic [RES_W-1:0] cfg_dst_res,
  input  logic [CW-1:0]    cfg_count,
  input  logic [IW-1:0]    cfg_interval,
  input  logic [SELW-1:0]  cfg_irq_sel,
  input  logic             ctl_we,
  input  logic [CHW-1:0]   ctl_ch,
  input  logic             ctl_en,
  input  logic [NRES-1:0]  res_ready,
  output logic             req_valid,
  output logic [CHW-1:0]   req_ch,
  output logic [RES_W-1:0] req_src_res,
  output logic [AW-1:0]    req_src_addr,
  output logic [RES_W-1:0] req_dst_res,
  output logic [AW-1:0]    req_dst_addr,
  output logic [NIRQ-1:0]  irq,
  output logic [NCH-1:0]   active
);
  logic [NCH-1:0]   elig, gnt, done;
  logic [AW-1:0]    saddr [NCH];
  logic [AW-1:0]    daddr [NCH];
  logic [RES_W-1:0] sres  [NCH];
  logic [RES_W-1:0] dres  [NCH];
  logic [SELW-1:0]  sel   [NCH];
  logic [CHW-1:0]   gidx;
  logic             gany;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_seq_chan #(.AW(AW), .CW(CW), .IW(IW), .SELW(SELW)) i_chan (
      .clk(clk), .rst(rst),
      .cfg_hit(cfg_we && (cfg_ch == CHW'(c))),
      .src_base(cfg_src_base), .src_inc(cfg_src_inc), .src_len(cfg_src_len),
      .src_circ(cfg_src_circ), .src_res(cfg_src_res),
      .dst_base(cfg_dst_base), .dst_inc(cfg_dst_inc), .dst_len(cfg_dst_len),
      .dst_circ(cfg_dst_circ), .dst_res(cfg_dst_res),
      .count(cfg_count), .interval(cfg_interval), .irq_sel(cfg_irq_sel),
      .ctl_hit(ctl_we && (ctl_ch == CHW'(c))), .ctl_en(ctl_en),
      .grant(gnt[c]), .res_ready(res_ready),
      .eligible(elig[c]), .src_addr(saddr[c]), .dst_addr(daddr[c]),
      .src_res_o(sres[c]), .dst_res_o(dres[c]), .done(done[c]),
      .sel_o(sel[c]), .active_o(active[c])
    );
  end

  dma_seq_rr #(.N(NCH)) i_rr (
    .clk(clk), .rst(rst), .req(elig), .gnt(gnt), .idx(gidx), .any(gany)
  );

  logic [AW-1:0]    g_saddr, g_daddr;
  logic [RES_W-1:0] g_sres, g_dres;
  logic [SELW-1:0]  g_sel;

  always_comb begin
    g_saddr = '0; g_daddr = '0; g_sres = '0; g_dres = '0; g_sel = '0;
    for (int c = 0; c < NCH; c++) begin
      if (gidx == CHW'(c)) begin
        g_saddr = saddr[c]; g_daddr = daddr[c];
        g_sres  = sres[c];  g_dres  = dres[c];
        g_sel   = sel[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0; req_ch <= '0;
      req_src_res <= '0; req_src_addr <= '0;
      req_dst_res <= '0; req_dst_addr <= '0;
      irq <= '0;
    end else begin
      req_valid    <= gany;
      req_ch       <= gidx;
      req_src_res  <= g_sres;
      req_src_addr <= g_saddr;
      req_dst_res  <= g_dres;
      req_dst_addr <= g_daddr;
      for (int i = 0; i < NIRQ; i++)
        irq[i] <= (|done) && (g_sel == SELW'(i));
    end
  end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NCH  = 8,
  parameter int NIRQ = 6,
  parameter int NRES = 4,
  localparam int CHW = $clog2(NCH),
  localparam int RW  = $clog2(NRES)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [CHW-1:0]  req_ch,
  input logic [RW-1:0]   req_src_res,
  input logic [RW-1:0]   req_dst_res,
  input logic [NRES-1:0] res_ready,
  input logic [NIRQ-1:0] irq,
  input logic [NCH-1:0]  active
);
  logic [NRES-1:0] rdy_q;
  logic [NCH-1:0]  act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= '0; act_q <= '0;
    end else begin
      rdy_q <= res_ready; act_q <= active;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && irq == '0 && active == '0));

  assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));

  assert_irq_with_req_R7: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> req_valid);

  assert_grant_was_active_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> act_q[req_ch]);

  assert_res_were_ready_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (rdy_q[req_src_res] && rdy_q[req_dst_res]));
endmodule

bind dma_seq dma_seq_chk #(.NCH(NCH), .NIRQ(NIRQ), .NRES(NRES)) i_dma_seq_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ch(req_ch),
  .req_src_res(req_src_res), .req_dst_res(req_dst_res),
  .res_ready(res_ready), .irq(irq), .active(active)
);

// File: tb/test_dma_seq.sv
`timescale 1ns/100ps
module test_dma_seq;
  localparam int NCH = 8, AW = 16, CW = 12, IW = 6, NIRQ = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [2:0] cfg_ch = 0;
  logic [15:0] cfg_src_base = 0, cfg_src_inc = 0, cfg_src_len = 0;
  logic [15:0] cfg_dst_base = 0, cfg_dst_inc = 0, cfg_dst_len = 0;
  logic cfg_src_circ = 0, cfg_dst_circ = 0;
  logic [1:0] cfg_src_res = 0, cfg_dst_res = 0;
  logic [11:0] cfg_count = 0; logic [5:0] cfg_interval = 0; logic [2:0] cfg_irq_sel = 0;
  logic ctl_we = 0; logic [2:0] ctl_ch = 0; logic ctl_en = 0;
  logic [3:0] res_ready = 0;
  logic req_valid; logic [2:0] req_ch; logic [1:0] req_src_res, req_dst_res;
  logic [15:0] req_src_addr, req_dst_addr; logic [5:0] irq; logic [7:0] active;

  always #2.5 clk = ~clk;

  dma_seq #(.NCH(NCH), .AW(AW), .CW(CW), .IW(IW), .NIRQ(NIRQ)) i_dma_seq (.*);

  int n_chk = 0, n_err = 0;
  string scen = "R1";

  // reference state
  int m_base[8][2], m_inc[8][2], m_len[8][2], m_circ[8][2], m_off[8][2], m_res[8][2];
  int m_rem[8], m_wt[8], m_iv[8], m_sel[8], m_ptr = 7;
  bit m_act[8];
  int e_v = 0, e_ch = 0, e_sa = 0, e_da = 0, e_sr = 0, e_dr = 0, e_sc = 0, e_dc = 0, e_irq = 0, e_act = 0;

  function automatic int step_off(int off, int inc, int len, int circ);
    int s = off + inc;
    if (circ != 0) begin
      if (s < 0) s += len;
      else if (s >= len) s -= len;
    end
    return s & 16'hFFFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", scen, tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit old_act[8];
    int g = -1;
    e_irq = 0;
    for (int c = 0; c < 8; c++) old_act[c] = m_act[c];
    for (int i = 1; i <= 8; i++) begin
      int k = (m_ptr + i) % 8;
      if (g < 0 && m_act[k] && m_rem[k] != 0 && m_wt[k] == 0 &&
          res_ready[m_res[k][0]] && res_ready[m_res[k][1]]) g = k;
    end
    e_v = (g >= 0);
    if (g >= 0) begin
      e_ch = g;
      e_sa = (m_base[g][0] + m_off[g][0]) & 16'hFFFF;
      e_da = (m_base[g][1] + m_off[g][1]) & 16'hFFFF;
      e_sr = m_res[g][0]; e_dr = m_res[g][1];
      e_sc = m_circ[g][0]; e_dc = m_circ[g][1];
      m_ptr = g;
    end
    for (int c = 0; c < 8; c++) begin
      if (c == g) begin
        m_rem[c]--; m_wt[c] = m_iv[c];
        for (int s = 0; s < 2; s++)
          m_off[c][s] = step_off(m_off[c][s], m_inc[c][s], m_len[c][s], m_circ[c][s]);
        if (m_rem[c] == 0) begin
          m_act[c] = 0;
          if (m_sel[c] < NIRQ) e_irq = 1 << m_sel[c];
        end
      end else if (m_wt[c] > 0) m_wt[c]--;
    end
    if (cfg_we && !old_act[cfg_ch]) begin
      m_base[cfg_ch][0] = cfg_src_base; m_inc[cfg_ch][0] = int'($signed(cfg_src_inc));
      m_len[cfg_ch][0] = cfg_src_len; m_circ[cfg_ch][0] = cfg_src_circ; m_res[cfg_ch][0] = cfg_src_res;
      m_base[cfg_ch][1] = cfg_dst_base; m_inc[cfg_ch][1] = int'($signed(cfg_dst_inc));
      m_len[cfg_ch][1] = cfg_dst_len; m_circ[cfg_ch][1] = cfg_dst_circ; m_res[cfg_ch][1] = cfg_dst_res;
      m_off[cfg_ch][0] = 0; m_off[cfg_ch][1] = 0;
      m_rem[cfg_ch] = cfg_count; m_wt[cfg_ch] = 0; m_iv[cfg_ch] = cfg_interval; m_sel[cfg_ch] = cfg_irq_sel;
    end
    if (ctl_we) m_act[ctl_ch] = ctl_en;
    e_act = 0;
    for (int c = 0; c < 8; c++) if (m_act[c]) e_act |= 1 << c;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk("R9 valid", req_valid, e_v);
    if (e_v) begin
      chk("R5 channel", req_ch, e_ch);
      chk("R6 src res", req_src_res, e_sr);
      chk("R6 dst res", req_dst_res, e_dr);
      chk(e_sc ? "R3 src addr" : "R2 src addr", req_src_addr, e_sa);
      chk(e_dc ? "R3 dst addr" : "R2 dst addr", req_dst_addr, e_da);
    end
    chk("R7 irq", irq, e_irq);
    chk("R7 active", active, e_act);
    cfg_we = 0; ctl_we = 0;
  endtask

  task automatic set_cfg(int ch, int sb, int si, int sl, int sc, int sr,
                         int db, int di, int dl, int dc, int dr, int cnt, int iv, int sel);
    cfg_we = 1; cfg_ch = 3'(ch);
    cfg_src_base = 16'(sb); cfg_src_inc = 16'(si); cfg_src_len = 16'(sl);
    cfg_src_circ = sc[0]; cfg_src_res = 2'(sr);
    cfg_dst_base = 16'(db); cfg_dst_inc = 16'(di); cfg_dst_len = 16'(dl);
    cfg_dst_circ = dc[0]; cfg_dst_res = 2'(dr);
    cfg_count = 12'(cnt); cfg_interval = 6'(iv); cfg_irq_sel = 3'(sel);
  endtask

  task automatic set_en(int ch, int en);
    ctl_we = 1; ctl_ch = 3'(ch); ctl_en = en[0];
  endtask

  task automatic rand_cfg(int ch);
    int sl = 2 + $urandom % 30, dl = 2 + $urandom % 30;
    int si = int'($urandom % (2 * sl + 1)) - sl;
    int di = int'($urandom % (2 * dl + 1)) - dl;
    int cnt = ($urandom % 10 == 0) ? 0 : 1 + $urandom % 15;
    set_cfg(ch, $urandom, si, sl, $urandom % 2, $urandom % 4,
            $urandom, di, dl, $urandom % 2, $urandom % 4,
            cnt, $urandom % 5, $urandom % 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 8; c++) begin
      m_act[c] = 0; m_rem[c] = 0; m_wt[c] = 0; m_iv[c] = 0; m_sel[c] = 0;
      for (int s = 0; s < 2; s++) begin
        m_base[c][s] = 0; m_inc[c][s] = 0; m_len[c][s] = 0;
        m_circ[c][s] = 0; m_off[c][s] = 0; m_res[c][s] = 0;
      end
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet out of reset
    chk("R1 valid", req_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 active", active, 0);
    rst = 0;
    res_ready = 4'hF;
    tick();

    // R2: linear, positive and negative increments
    scen = "R2";
    set_cfg(2, 16'h0100, 4, 0, 0, 0, 16'h8000, -1, 0, 0, 3, 3, 0, 1);
    set_en(2, 1);
    repeat (5) tick();

    // R3: circular wrap in both directions
    scen = "R3";
    set_cfg(5, 16'h0040, 3, 8, 1, 1, 16'h0200, -3, 8, 1, 2, 10, 0, 4);
    set_en(5, 1);
    repeat (12) tick();

    // R4: interval 3 spaces grants four cycles apart
    scen = "R4";
    set_cfg(0, 16'h1000, 1, 0, 0, 0, 16'h2000, 1, 0, 0, 1, 4, 3, 0);
    set_en(0, 1);
    repeat (20) tick();

    // R5 and R6: three channels competing under varying readiness
    scen = "R6";
    set_cfg(1, 16'h3000, 1, 0, 0, 0, 16'h3100, 1, 0, 0, 1, 6, 0, 2); set_en(1, 1); tick();
    set_cfg(3, 16'h4000, 2, 0, 0, 2, 16'h4100, 2, 0, 0, 3, 6, 0, 3); set_en(3, 1); tick();
    set_cfg(6, 16'h5000, 1, 0, 0, 1, 16'h5100, 1, 0, 0, 0, 6, 0, 5); set_en(6, 1); tick();
    for (int i = 0; i < 30; i++) begin
      res_ready = 4'($urandom);
      tick();
    end
    res_ready = 4'hF;
    repeat (10) tick();

    // R8: descriptor written while the channel runs is dropped
    scen = "R8";
    set_cfg(4, 16'h6000, 1, 0, 0, 0, 16'h6100, 1, 0, 0, 0, 8, 2, 1); set_en(4, 1);
    repeat (2) tick();
    set_cfg(4, 16'h7777, 5, 0, 0, 3, 16'h7000, 5, 0, 0, 3, 2, 0, 0);
    repeat (30) tick();

    // R10: selector out of range yields no pulse
    scen = "R10";
    set_cfg(7, 16'h0010, 1, 0, 0, 0, 16'h0020, 1, 0, 0, 0, 1, 0, 6); set_en(7, 1);
    repeat (4) tick();
    set_cfg(7, 16'h0010, 1, 0, 0, 0, 16'h0020, 1, 0, 0, 0, 2, 0, 7); set_en(7, 1);
    repeat (5) tick();

    // R11: enabled with a zero count never issues
    scen = "R11";
    set_cfg(6, 16'h0A00, 1, 0, 0, 0, 16'h0B00, 1, 0, 0, 0, 0, 0, 0); set_en(6, 1);
    repeat (6) tick();
    set_en(6, 0); tick();

    // random mix
    scen = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 16;
      int ch = $urandom % 8;
      res_ready = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      if (r < 3) begin
        rand_cfg(ch);
        if (r < 2) set_en(ch, 1);
      end else if (r == 3) begin
        set_en(ch, $urandom % 4 == 0 ? 0 : 1);
      end
      tick();
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule